// File: doc/BRIEF.md
# Color Bar Background Overlay Mixer

This block produces an uninterrupted output video frame of fixed size on a two-pixels-per-beat stream. Every pixel that is not supplied by the input layer comes from a self-generated background of eight vertical color bars. Because of this, the output keeps running with a clean picture whether or not an input source is attached.

A single input layer can be switched on by control software once the upstream video is stable. While it is on, the layer's beats are placed unchanged inside a programmable rectangle, in raster order. Layer settings are written through a small register port. They are taken into use only when a frame ends, so a frame is never torn mid-picture.

Inside the rectangle the block waits for input rather than inventing pixels. At the start of each frame it drops stray input beats until it sees a start-of-frame marker. An input line that ends early is padded with background up to the end of that layer row.

Top module: `bar_overlay_mixer`

## Requirements
- R1: The output is a raster of FRAME_W/2 beats per line and FRAME_H lines, repeated without end. `outSof` is high on beat (0,0) only, and `outEol` is high on the last beat of every line. Outside the layer, `outValid` is 1 whatever the input does, and the beat position advances only on `outValid && outReady`.
- R2: Background beats show eight bars of equal width (FRAME_W/8 pixels), from left to right: white, yellow, cyan, green, magenta, red, blue, black. Each component is either all ones or zero. A pixel is packed as {R,G,B}, with R in the most significant COMP_W bits. Pixel 0 (the left one) sits in bits [3*COMP_W-1:0] of a beat, and pixel 1 sits above it.
- R3: The control registers are written through `cfgWe`, `cfgAddr` and `cfgWdata`:
  - address 0: bit 0 is the layer enable;
  - address 1: X offset in pixels in bits [15:0], Y offset in lines in bits [31:16];
  - address 2: layer width in pixels in bits [15:0], height in lines in bits [31:16];
  - address 3: writes are ignored;
  - bit 0 of the X offset and of the width is ignored, so both are whole beats;
  - after reset the layer is disabled, the offset is 0 and the size is the full frame.
- R4: A register write takes effect only from the frame that follows the acceptance of the current frame's last beat. Mid-frame writes leave the running frame unchanged.
- R5: While the layer is disabled, `inReady` is 0 and the output is background only.
- R6: While the layer is enabled, beats inside the rectangle carry the accepted input beats unchanged, in raster order. The rectangle is clipped at the frame edges, and beats outside it are background.
- R7: Inside the rectangle, when no usable input beat is present, `outValid` is 0 (the output stalls).
- R8: Inside the rectangle, until the frame's first start-of-frame input beat is accepted, input beats without `inSof` are consumed and dropped (`inReady` 1, `outValid` 0).
- R9: After an input beat carrying `inEol` has been placed, the remaining rectangle beats of that output line are background and take no input.
- R10: A layer of full frame size at offset 0 supplies every output beat from the input.
- R11: Apart from dropped beats, an input beat is consumed only in the same cycle as an output beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register address |
| cfgWdata | input | 32 | Register write data |
| inData | input | 6*COMP_W | Input layer beat, two pixels |
| inValid | input | 1 | Input beat valid |
| inSof | input | 1 | Input beat is first of a frame |
| inEol | input | 1 | Input beat is last of a line |
| inReady | output | 1 | Input beat consumed |
| outData | output | 6*COMP_W | Output beat, two pixels |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts beat |
| outSof | output | 1 | Output beat is first of frame |
| outEol | output | 1 | Output beat is last of line |

## Verification
The assertions check the following on every cycle:
- settings stay frozen except at a frame end;
- markers hold still under back-pressure;
- input is never taken while the layer is off;
- input is consumed only together with an output beat or as a drop;
- only beats without a start marker are dropped, and only before sync;
- background components are full-scale or zero;
- the output stalls inside the rectangle when input is missing.

Only the bench's scenarios can show the rest:
- the bar order;
- the rectangle placement and clipping;
- the frame-boundary timing of register writes;
- the short-line padding;
- the raster-order pass-through of input data.

// File: rtl/bom_pkg.sv
`timescale 1ns/1ps
package bom_pkg;
  localparam int BEAT_PIX     = 2;
  localparam int COMP_PER_PIX = 3;
  localparam int NUM_BARS     = 8;
  localparam int BAR_IDX_W    = 3;

  localparam logic [1:0] ADDR_ENABLE = 2'd0;
  localparam logic [1:0] ADDR_OFFSET = 2'd1;
  localparam logic [1:0] ADDR_SIZE   = 2'd2;

  // Layer settings held in beat units horizontally, lines vertically
  typedef struct packed {
    logic        en;
    logic [14:0] xBeat;
    logic [15:0] yLine;
    logic [14:0] wBeat;
    logic [15:0] hLine;
  } layer_cfg_t;

  // Strobes from control to datapath for the current output beat
  typedef struct packed {
    logic                 layerOn;
    logic                 inLayer;
    logic                 sof;
    logic                 eol;
    logic                 last;
    logic [BAR_IDX_W-1:0] bar;
  } strobe_t;
endpackage

// File: rtl/bom_ctrl.sv
`timescale 1ns/1ps
module bom_ctrl
  import bom_pkg::*;
#(
  parameter int FRAME_W = 3840,
  parameter int FRAME_H = 2160
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [1:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  input  logic        beatTaken,
  output strobe_t     stb
);
  localparam int LINE_BEATS = FRAME_W / BEAT_PIX;
  localparam int BAR_BEATS  = LINE_BEATS / NUM_BARS;
  localparam int BXW = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
  localparam int BYW = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;
  localparam int BCW = (BAR_BEATS > 1) ? $clog2(BAR_BEATS) : 1;
  localparam logic [BXW-1:0] LAST_BX = BXW'(LINE_BEATS - 1);
  localparam logic [BYW-1:0] LAST_BY = BYW'(FRAME_H - 1);
  localparam logic [BCW-1:0] LAST_BC = BCW'(BAR_BEATS - 1);
  localparam layer_cfg_t CFG_RESET = '{
    en: 1'b0, xBeat: 15'd0, yLine: 16'd0,
    wBeat: 15'(LINE_BEATS), hLine: 16'(FRAME_H)};

  layer_cfg_t shadowCfg, activeCfg;
  logic [BXW-1:0] bx;
  logic [BYW-1:0] by;
  logic [BCW-1:0] barCnt;
  logic [BAR_IDX_W-1:0] barIdx;
  logic atEol, atBottom, frameEnd, inRect;
  logic [16:0] bxExt, byExt, xEnd, yEnd;

  // Register file written by software, visible only after a frame end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCfg <= CFG_RESET;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_ENABLE: shadowCfg.en <= cfgWdata[0];
        ADDR_OFFSET: begin
          shadowCfg.xBeat <= cfgWdata[15:1];
          shadowCfg.yLine <= cfgWdata[31:16];
        end
        ADDR_SIZE: begin
          shadowCfg.wBeat <= cfgWdata[15:1];
          shadowCfg.hLine <= cfgWdata[31:16];
        end
        default: ;
      endcase
    end
  end

  assign atEol    = (bx == LAST_BX);
  assign atBottom = (by == LAST_BY);
  assign frameEnd = beatTaken && atEol && atBottom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         activeCfg <= CFG_RESET;
    else if (frameEnd) activeCfg <= shadowCfg;
  end

  // Raster position and bar tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bx     <= '0;
      by     <= '0;
      barCnt <= '0;
      barIdx <= '0;
    end else if (beatTaken) begin
      if (atEol) begin
        bx     <= '0;
        barCnt <= '0;
        barIdx <= '0;
        by     <= atBottom ? '0 : by + 1'b1;
      end else begin
        bx <= bx + 1'b1;
        if (barCnt == LAST_BC) begin
          barCnt <= '0;
          barIdx <= barIdx + 1'b1;
        end else begin
          barCnt <= barCnt + 1'b1;
        end
      end
    end
  end

  assign bxExt = 17'(bx);
  assign byExt = 17'(by);
  assign xEnd  = 17'(activeCfg.xBeat) + 17'(activeCfg.wBeat);
  assign yEnd  = 17'(activeCfg.yLine) + 17'(activeCfg.hLine);
  assign inRect = activeCfg.en &&
                  (bxExt >= 17'(activeCfg.xBeat)) && (bxExt < xEnd) &&
                  (byExt >= 17'(activeCfg.yLine)) && (byExt < yEnd);

  always_comb begin
    stb.layerOn = activeCfg.en;
    stb.inLayer = inRect;
    stb.sof     = (bx == '0) && (by == '0);
    stb.eol     = atEol;
    stb.last    = atEol && atBottom;
    stb.bar     = barIdx;
  end

  // R4: settings in use only change when a frame's last beat is accepted
  a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(activeCfg));
endmodule

// File: rtl/bom_dp.sv
`timescale 1ns/1ps
module bom_dp
  import bom_pkg::*;
#(
  parameter int COMP_W = 10
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  strobe_t                                 stb,
  input  logic [BEAT_PIX*COMP_PER_PIX*COMP_W-1:0] inData,
  input  logic                                    inValid,
  input  logic                                    inSof,
  input  logic                                    inEol,
  output logic                                    inReady,
  output logic [BEAT_PIX*COMP_PER_PIX*COMP_W-1:0] outData,
  output logic                                    outValid,
  input  logic                                    outReady,
  output logic                                    outSof,
  output logic                                    outEol,
  output logic                                    beatTaken
);
  localparam int PIX_W  = COMP_PER_PIX * COMP_W;
  localparam int BEAT_W = BEAT_PIX * PIX_W;
  localparam int NCOMP  = BEAT_PIX * COMP_PER_PIX;

  logic synced, rowDone;
  logic needIn, dropBeat, takeIn;
  logic [PIX_W-1:0]  barPix;
  logic [BEAT_W-1:0] barBeat;

  assign needIn    = stb.inLayer && !rowDone;
  assign dropBeat  = needIn && !synced && inValid && !inSof;
  assign outValid  = !needIn || (inValid && !dropBeat);
  assign inReady   = needIn && (dropBeat || outReady);
  assign beatTaken = outValid && outReady;
  assign takeIn    = needIn && inValid && inReady && !dropBeat;
  assign outSof    = stb.sof;
  assign outEol    = stb.eol;

  // Frame sync: cleared at frame end, set by the first placed input beat
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        synced <= 1'b0;
    else if (beatTaken && stb.last)   synced <= 1'b0;
    else if (takeIn)                  synced <= 1'b1;
  end

  // Short input line: rest of the layer row is background
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        rowDone <= 1'b0;
    else if (beatTaken && stb.eol)    rowDone <= 1'b0;
    else if (takeIn && inEol)         rowDone <= 1'b1;
  end

  // Bar colour: red off for bars 2,3,6,7; green off for 4..7; blue off for odd
  assign barPix = {{COMP_W{~stb.bar[1]}}, {COMP_W{~stb.bar[2]}}, {COMP_W{~stb.bar[0]}}};

  for (genvar p = 0; p < BEAT_PIX; p++) begin : g_pix
    assign barBeat[p*PIX_W +: PIX_W] = barPix;
  end

  assign outData = needIn ? inData : barBeat;

  // R5: no input is taken while the layer is off
  a_r5_off_no_ready: assert property (@(posedge clk) disable iff (!rstN)
    !stb.layerOn |-> !inReady);

  // R11: a placed input beat travels with an accepted output beat
  a_r11_in_with_out: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && outValid) |-> outReady);

  // R8: only beats without a start marker are dropped, and only before sync
  a_r8_drop_only_unsynced: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !outValid) |-> (!inSof && !synced));

  // R7: missing input inside the rectangle stalls the output
  a_r7_stall: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inLayer && !rowDone && !inValid) |-> !outValid);

  // R1: line and frame markers hold while the output is back-pressured
  a_r1_hold_markers: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outSof) && $stable(outEol)));

  // R2: background components are full scale or zero
  for (genvar c = 0; c < NCOMP; c++) begin : g_lvl
    a_r2_bar_levels: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && !needIn) |->
        ((outData[c*COMP_W +: COMP_W] == '0) || (outData[c*COMP_W +: COMP_W] == '1)));
  end
endmodule

// File: rtl/bar_overlay_mixer.sv
`timescale 1ns/1ps
module bar_overlay_mixer
  import bom_pkg::*;
#(
  parameter int FRAME_W = 3840,
  parameter int FRAME_H = 2160,
  parameter int COMP_W  = 10
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    cfgWe,
  input  logic [1:0]                              cfgAddr,
  input  logic [31:0]                             cfgWdata,
  input  logic [BEAT_PIX*COMP_PER_PIX*COMP_W-1:0] inData,
  input  logic                                    inValid,
  input  logic                                    inSof,
  input  logic                                    inEol,
  output logic                                    inReady,
  output logic [BEAT_PIX*COMP_PER_PIX*COMP_W-1:0] outData,
  output logic                                    outValid,
  input  logic                                    outReady,
  output logic                                    outSof,
  output logic                                    outEol
);
  strobe_t stb;
  logic    beatTaken;

  bom_ctrl #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .beatTaken(beatTaken), .stb(stb));

  bom_dp #(.COMP_W(COMP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inData(inData), .inValid(inValid), .inSof(inSof), .inEol(inEol),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outSof(outSof), .outEol(outEol),
    .beatTaken(beatTaken));
endmodule

// File: tb/bar_overlay_mixer_test.sv
`timescale 1ns/1ps
module bar_overlay_mixer_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 64;
  localparam int FH = 6;
  localparam int CW = 10;
  localparam int LB = FW / 2;
  localparam int BW = 6 * CW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [BW-1:0] inData = '0;
  logic inValid = 1'b0, inSof = 1'b0, inEol = 1'b0;
  logic inReady;
  logic [BW-1:0] outData;
  logic outValid, outSof, outEol;
  logic outReady = 1'b0;

  bar_overlay_mixer #(.FRAME_W(FW), .FRAME_H(FH), .COMP_W(CW)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .inData(inData), .inValid(inValid), .inSof(inSof), .inEol(inEol),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outSof(outSof), .outEol(outEol));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nVec = 0, nBad = 0;
  int pEn = 0, pX = 0, pY = 0, pW = LB, pH = FH;
  int cEn = 0, cX = 0, cY = 0, cW = LB, cH = FH;
  int ebx = 0, eby = 0, framesDone = 0;
  bit mSynced = 0, mRowDone = 0;
  logic [BW-1:0] sData;
  bit sSof, sEol, sHeld = 0;
  int sCol = 0, sRow = 0, sJunk = 0;
  int srcLen = 1, srcRows = 1, junkMax = 0;
  int validPct = 70, readyPct = 70;
  string tagOvr = "";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] expBar(input int col);
    int idx;
    logic [2:0] rgb;
    logic [3*CW-1:0] pix;
    idx = col / (LB / 8);
    case (idx)
      0: rgb = 3'b111; 1: rgb = 3'b110; 2: rgb = 3'b011; 3: rgb = 3'b010;
      4: rgb = 3'b101; 5: rgb = 3'b100; 6: rgb = 3'b001; default: rgb = 3'b000;
    endcase
    pix = {{CW{rgb[2]}}, {CW{rgb[1]}}, {CW{rgb[0]}}};
    return {pix, pix};
  endfunction

  function automatic bit inRectM();
    return (cEn != 0) && ebx >= cX && ebx < cX + cW && eby >= cY && eby < cY + cH;
  endfunction

  task automatic srcLoad();
    sData = BW'({$urandom, $urandom});
    sSof = (sJunk == 0) && (sCol == 0) && (sRow == 0);
    sEol = (sJunk == 0) ? (sCol >= srcLen - 1) : 1'($urandom % 2);
  endtask

  task automatic srcNext();
    if (sJunk > 0) sJunk--;
    else if (sCol >= srcLen - 1) begin
      sCol = 0;
      if (sRow >= srcRows - 1) begin
        sRow = 0;
        sJunk = $urandom % (junkMax + 1);
      end else sRow++;
    end else sCol++;
    srcLoad();
  endtask

  task automatic cycle();
    bit need, drop, eV, eR, take;
    logic [BW-1:0] eData;
    string dtag;
    @(negedge clk);
    if (!sHeld) sHeld = ($urandom % 100) < validPct;
    inValid = sHeld; inData = sData; inSof = sSof; inEol = sEol;
    outReady = ($urandom % 100) < readyPct;
    #1;
    need = inRectM() && !mRowDone;
    drop = need && !mSynced && inValid && !inSof;
    eV = !need || (inValid && !drop);
    eR = need && (drop || outReady);
    chk(outValid == eV, need ? "R7" : "R1", "outValid", 64'(outValid), 64'(eV));
    chk(inReady == eR, (cEn == 0) ? "R5" : (drop ? "R8" : "R11"), "inReady",
        64'(inReady), 64'(eR));
    if (eV && outReady) begin
      eData = need ? inData : expBar(ebx);
      dtag = (tagOvr != "") ? tagOvr : (need ? "R6" : "R2");
      chk(outData == eData, dtag, "outData", 64'(outData), 64'(eData));
      chk(outSof == (ebx == 0 && eby == 0) && outEol == (ebx == LB - 1), "R1",
          "markers", 64'({outSof, outEol}), 64'({ebx == 0 && eby == 0, ebx == LB - 1}));
    end
    take = eR && inValid;
    if (take && !drop) begin
      mSynced = 1;
      if (inEol) mRowDone = 1;
    end
    if (eV && outReady) begin
      if (ebx == LB - 1) begin
        ebx = 0; mRowDone = 0;
        if (eby == FH - 1) begin
          eby = 0; mSynced = 0; framesDone++;
          cEn = pEn; cX = pX; cY = pY; cW = pW; cH = pH;
        end else eby++;
      end else ebx++;
    end
    if (take) begin
      sHeld = 0;
      srcNext();
    end
  endtask

  task automatic writeCfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    outReady = 0; inValid = 0;
    cfgWe = 1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 0;
    case (a)
      2'd0: pEn = int'(d[0]);
      2'd1: begin pX = int'(d[15:1]); pY = int'(d[31:16]); end
      2'd2: begin pW = int'(d[15:1]); pH = int'(d[31:16]); end
      default: ;
    endcase
  endtask

  task automatic runFrames(input int n);
    int target;
    target = framesDone + n;
    while (framesDone < target) cycle();
  endtask

  task automatic setLayer(input int xp, input int yl, input int wp, input int hl);
    writeCfg(2'd1, {16'(yl), 16'(xp)});
    writeCfg(2'd2, {16'(hl), 16'(wp)});
  endtask

  initial begin
    void'($urandom(32'd2024));
    srcLoad();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    outReady = 0;
    #1;
    // Reset state: disabled layer, background white bar at origin
    chk(outValid == 1'b1, "R1", "reset outValid", 64'(outValid), 64'd1);
    chk(outSof == 1'b1, "R1", "reset outSof", 64'(outSof), 64'd1);
    chk(inReady == 1'b0, "R3", "reset layer off", 64'(inReady), 64'd0);
    chk(outData == expBar(0), "R2", "reset bar", 64'(outData), 64'(expBar(0)));

    // Disabled layer: background only (R5, R2, R1)
    validPct = 60; readyPct = 70;
    runFrames(2);

    // Enable a layer mid-frame: applies at next frame (R4), junk dropped (R8)
    srcLen = 10; srcRows = 3; junkMax = 3;
    runFrames(0); repeat (40) cycle();
    setLayer(10, 1, 20, 3);
    writeCfg(2'd0, 32'd1);
    tagOvr = "R4";
    runFrames(1);
    tagOvr = "";
    runFrames(3);

    // Full-size layer covers every beat (R10)
    srcLen = LB; srcRows = FH; junkMax = 0;
    setLayer(0, 0, FW, FH);
    runFrames(1);
    tagOvr = "R10";
    runFrames(2);
    tagOvr = "";

    // Rectangle clipped at the right and bottom edges (R6)
    srcLen = 7; srcRows = 2; junkMax = 2;
    setLayer(50, 4, 40, 10);
    runFrames(3);

    // Odd offset and width lose bit 0; address 3 ignored (R3)
    srcLen = 10; srcRows = 2;
    setLayer(11, 2, 21, 2);
    writeCfg(2'd3, 32'hFFFF_FFFF);
    runFrames(1);
    tagOvr = "R3";
    runFrames(2);

    // Short input lines padded with background (R9)
    srcLen = 6; srcRows = 3;
    setLayer(10, 1, 20, 3);
    runFrames(1);
    tagOvr = "R9";
    runFrames(3);
    tagOvr = "";

    // Back-pressure and input starvation (R7, R11)
    srcLen = 10;
    validPct = 90; readyPct = 20; runFrames(1);
    validPct = 20; readyPct = 95; runFrames(1);
    validPct = 70; readyPct = 70;

    // Disable again (R5)
    writeCfg(2'd0, 32'd0);
    runFrames(1);
    tagOvr = "R5";
    runFrames(2);
    tagOvr = "";

    // Random layouts with writes landing mid-frame
    for (int it = 0; it < 10; it++) begin
      int xp, yl, wp, hl, xb, wb;
      xp = $urandom % (FW + 8); yl = $urandom % (FH + 2);
      wp = 2 + ($urandom % FW); hl = 1 + ($urandom % FH);
      xb = xp / 2; wb = wp / 2;
      srcLen = (xb >= LB) ? 1 : (((xb + wb > LB) ? LB : xb + wb) - xb);
      if (srcLen < 1) srcLen = 1;
      srcRows = (yl >= FH) ? 1 : (((yl + hl > FH) ? FH : yl + hl) - yl);
      junkMax = $urandom % 3;
      repeat ($urandom % 150) cycle();
      setLayer(xp, yl, wp, hl);
      writeCfg(2'd0, 32'($urandom % 4 != 0));
      runFrames(2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule